// File: doc/BRIEF.md
# Receive Character Timeout Timer

This block provides the receive-timeout interrupt of a 16550-style UART receive path. When the receive FIFO holds some characters, but fewer than the host's trigger level, the host would otherwise never be told that data is waiting. The block counts ticks from the baud-rate generator, starting from a reload value. If neither side touches the FIFO before the count runs out, it raises a timeout interrupt towards the host.

Only the local controller can program the reload value, through a dedicated write strobe. The block has no host-side path to it. Software converts the desired delay, usually about four character times, into a tick count. A controller push into the FIFO, or a host pop from it, starts the interval again. The FIFO storage lives outside this block. The block sees only the FIFO's occupancy, the trigger level and the two access strobes.

Top module: `rx_char_timeout`

## Requirements
- R1: The countdown advances by one only in cycles where `baud_tick` is high. In any other cycle it holds its value.
- R2: The reload register is loaded only by `ctl_reload_wr`, and it resets to zero. The host has no port that reaches it, and reset leaves `timeout_irq` low.
- R3: A cycle with `ctl_fifo_wr` or `host_fifo_rd` high restarts the countdown at the reload value. Any ticks seen before that access do not count toward the timeout.
- R4: The timeout is armed only while 0 < `fifo_count` < `trig_level`. At or above the trigger level, ticks never raise `timeout_irq`.
- R5: `timeout_irq` falls in the cycle after an access strobe, and it also falls in the cycle after `fifo_count` reaches `trig_level` or 0.
- R6: While the FIFO is empty, the counter holds at the reload value. Once data appears, a full reload-value worth of ticks is needed before the timeout.
- R7: With reload value N > 0, `timeout_irq` rises in the cycle after the N-th armed tick following a restart. It then stays high through further ticks and idle cycles until a clearing event, and the counter does not reload by itself.
- R8: A reload value of zero never produces `timeout_irq`, whatever the ticks.
- R9: Writing a new reload value does not change a countdown already in progress. The new value is first used at the next restart or while the timer is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_reload_wr | input | 1 | Controller strobe that writes the reload register |
| ctl_reload_data | input | CNT_W | Reload value written by the controller |
| ctl_fifo_wr | input | 1 | Controller push into the receive FIFO |
| host_fifo_rd | input | 1 | Host pop from the receive FIFO |
| baud_tick | input | 1 | Single-cycle enable from the baud-rate generator |
| fifo_count | input | LVL_W | Current receive FIFO occupancy |
| trig_level | input | LVL_W | Host-programmed trigger level |
| timeout_irq | output | 1 | Character-timeout interrupt to the host |

## Verification
The assertions assume that `baud_tick` is a clean single-cycle enable and that `fifo_count` and `trig_level` are stable, synchronous values. They do not assume any relationship between an access strobe and the occupancy it produces, so occupancy may change in a cycle with no strobe. The stimulus drives every input just after a falling edge and never raises a tick in the same cycle as an access strobe or a reload write. This keeps each expected tick count unambiguous. Occupancy is sometimes changed without a strobe, on purpose, to exercise arming and disarming on their own.

// File: rtl/rct_pkg.sv
// Shared constants and types for the receive character timeout timer.
// Assumes a FIFO of modest depth and a reload width sized by software needs.
package rct_pkg;
    localparam int RCT_CNT_W = 16;
    localparam int RCT_DEPTH = 16;

    // Countdown state: holding the reload, counting, or expired.
    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_COUNT = 2'd1,
        ST_DONE  = 2'd2
    } rct_state_e;
endpackage

// File: rtl/rct_reload_reg.sv
// Reload register for the timeout countdown.
// Only the controller write strobe updates it. It assumes the data is
// valid in the same cycle as the strobe.
module rct_reload_reg #(
    parameter int             W         = 16,
    parameter logic [W-1:0]   RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] value
);
    logic [W-1:0] value_q;

    // Capture a new reload value on a controller write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= RESET_VAL;
        end else if (wr_en) begin
            value_q <= wr_data;
        end
    end

    assign value = value_q;
endmodule

// File: rtl/rct_arm_logic.sv
// Decides whether the timeout may run and whether it must restart.
// Assumes fifo_count and trig_level share one width and are synchronous.
module rct_arm_logic #(
    parameter int LVL_W = 5
) (
    input  logic [LVL_W-1:0] fifo_count,
    input  logic [LVL_W-1:0] trig_level,
    input  logic             push,
    input  logic             pop,
    output logic             armed,
    output logic             restart
);
    logic not_empty;
    logic below_trig;

    // Occupancy window: some data present, but fewer than the trigger.
    always_comb begin
        not_empty  = (fifo_count != '0);
        below_trig = (fifo_count < trig_level);
        armed      = not_empty && below_trig;
    end

    // Any access from either side restarts the interval.
    always_comb begin
        restart = push || pop;
    end
endmodule

// File: rtl/rct_down_counter.sv
// Baud-tick down counter with a sticky expiry state.
// Loads the reload value whenever it is disarmed or restarted. Counts down
// on ticks while armed, and stops in ST_DONE on reaching zero. A zero reload
// never expires. Assumes tick is a single-cycle enable.
module rct_down_counter #(
    parameter int           W         = 16,
    parameter logic [W-1:0] RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         armed,
    input  logic         restart,
    input  logic         tick,
    input  logic [W-1:0] reload,
    output logic [W-1:0] count,
    output logic         expired
);
    import rct_pkg::*;

    localparam logic [W-1:0] ONE = W'(1);

    rct_state_e   st_q;
    logic [W-1:0] cnt_q;
    logic         can_step;

    // A step is allowed only while armed, on a tick, and before expiry.
    always_comb begin
        can_step = armed && !restart && tick && (st_q != ST_DONE) && (cnt_q != '0);
    end

    // Countdown and state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RESET_VAL;
            st_q  <= ST_HOLD;
        end else if (restart || !armed) begin
            cnt_q <= reload;
            st_q  <= ST_HOLD;
        end else if (can_step) begin
            cnt_q <= cnt_q - ONE;
            st_q  <= (cnt_q == ONE) ? ST_DONE : ST_COUNT;
        end
    end

    assign count   = cnt_q;
    assign expired = (st_q == ST_DONE);
endmodule

// File: rtl/rx_char_timeout.sv
// Receive character timeout timer (top).
// Raises timeout_irq when the FIFO holds data below the trigger level and
// no push or pop happens within the programmed number of baud ticks.
// Assumes all inputs are synchronous to clk.
module rx_char_timeout #(
    parameter int                             CNT_W        = rct_pkg::RCT_CNT_W,
    parameter int                             DEPTH        = rct_pkg::RCT_DEPTH,
    parameter logic [CNT_W-1:0]               RESET_RELOAD = '0,
    localparam int                            LVL_W        = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_reload_wr,
    input  logic [CNT_W-1:0] ctl_reload_data,
    input  logic             ctl_fifo_wr,
    input  logic             host_fifo_rd,
    input  logic             baud_tick,
    input  logic [LVL_W-1:0] fifo_count,
    input  logic [LVL_W-1:0] trig_level,
    output logic             timeout_irq
);
    logic [CNT_W-1:0] reload_val;
    logic [CNT_W-1:0] count_q;
    logic             armed;
    logic             restart;
    logic             expired;

    rct_reload_reg #(
        .W         (CNT_W),
        .RESET_VAL (RESET_RELOAD)
    ) u_reload (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctl_reload_wr),
        .wr_data (ctl_reload_data),
        .value   (reload_val)
    );

    rct_arm_logic #(
        .LVL_W (LVL_W)
    ) u_arm (
        .fifo_count (fifo_count),
        .trig_level (trig_level),
        .push       (ctl_fifo_wr),
        .pop        (host_fifo_rd),
        .armed      (armed),
        .restart    (restart)
    );

    rct_down_counter #(
        .W         (CNT_W),
        .RESET_VAL (RESET_RELOAD)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .armed   (armed),
        .restart (restart),
        .tick    (baud_tick),
        .reload  (reload_val),
        .count   (count_q),
        .expired (expired)
    );

    assign timeout_irq = expired;
endmodule

// File: rtl/rct_checker.sv
// Property checker for rx_char_timeout, attached with bind.
// Assumes it observes the top's ports plus the countdown value.
module rct_checker #(
    parameter int CNT_W = 16,
    parameter int LVL_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_fifo_wr,
    input logic             host_fifo_rd,
    input logic             baud_tick,
    input logic [LVL_W-1:0] fifo_count,
    input logic [LVL_W-1:0] trig_level,
    input logic             timeout_irq,
    input logic [CNT_W-1:0] count_q
);
    logic chk_armed;
    logic chk_access;

    // Independent view of the arming window and access events.
    always_comb begin
        chk_armed  = (fifo_count != '0) && (fifo_count < trig_level);
        chk_access = ctl_fifo_wr || host_fifo_rd;
    end

    AST_COUNT_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed && !chk_access && !baud_tick) |=> $stable(count_q)); // R1
    AST_RISE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_irq) |-> $past(baud_tick)); // R1
    AST_ACCESS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        chk_access |=> !timeout_irq); // R5
    AST_IRQ_NEEDS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_irq |-> $past(chk_armed)); // R4
    AST_EMPTY_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_count == '0) |=> !timeout_irq); // R6
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_irq && chk_armed && !chk_access) |=> timeout_irq); // R7
endmodule

bind rx_char_timeout rct_checker #(
    .CNT_W (CNT_W),
    .LVL_W (LVL_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl_fifo_wr  (ctl_fifo_wr),
    .host_fifo_rd (host_fifo_rd),
    .baud_tick    (baud_tick),
    .fifo_count   (fifo_count),
    .trig_level   (trig_level),
    .timeout_irq  (timeout_irq),
    .count_q      (count_q)
);

// File: tb/rx_char_timeout_test.sv
// Directed bench for rx_char_timeout: one task per scenario.
module rx_char_timeout_test;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int LVL_W      = 5;
    localparam int WATCHDOG   = 20000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ctl_reload_wr = 1'b0;
    logic [CNT_W-1:0] ctl_reload_data = '0;
    logic             ctl_fifo_wr = 1'b0;
    logic             host_fifo_rd = 1'b0;
    logic             baud_tick = 1'b0;
    logic [LVL_W-1:0] fifo_count = '0;
    logic [LVL_W-1:0] trig_level = 5'd4;
    logic             timeout_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    rx_char_timeout uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .ctl_reload_wr   (ctl_reload_wr),
        .ctl_reload_data (ctl_reload_data),
        .ctl_fifo_wr     (ctl_fifo_wr),
        .host_fifo_rd    (host_fifo_rd),
        .baud_tick       (baud_tick),
        .fifo_count      (fifo_count),
        .trig_level      (trig_level),
        .timeout_irq     (timeout_irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic exp);
        checks++;
        if (timeout_irq !== exp) begin
            errors++;
            $display("FAIL %s: timeout_irq=%0b expected %0b", req, timeout_irq, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic ticks(input int n);
        baud_tick = 1'b1;
        cyc(n);
        baud_tick = 1'b0;
    endtask

    task automatic push();
        ctl_fifo_wr = 1'b1;
        cyc(1);
        ctl_fifo_wr = 1'b0;
    endtask

    task automatic pop();
        host_fifo_rd = 1'b1;
        cyc(1);
        host_fifo_rd = 1'b0;
    endtask

    task automatic set_reload(input int v);
        ctl_reload_wr   = 1'b1;
        ctl_reload_data = CNT_W'(v);
        cyc(1);
        ctl_reload_wr   = 1'b0;
    endtask

    task automatic t_reset();
        check("R2 reset", 1'b0);
        fifo_count = 5'd2;
        trig_level = 5'd8;
        push();
        ticks(20);
        check("R2 zero after reset", 1'b0);
        trig_level = 5'd4;
    endtask

    task automatic t_basic();
        set_reload(5);
        fifo_count = 5'd1;
        push();
        ticks(4);
        check("R7 before expiry", 1'b0);
        ticks(1);
        check("R7 at expiry", 1'b1);
        ticks(3);
        check("R7 hold on ticks", 1'b1);
        cyc(4);
        check("R7 hold idle", 1'b1);
        pop();
        check("R5 clear on read", 1'b0);
        ticks(2);
        cyc(3);
        ticks(2);
        check("R1 gaps do not count", 1'b0);
        ticks(1);
        check("R1 expiry after gapped ticks", 1'b1);
    endtask

    task automatic t_restart();
        push();
        check("R5 clear on write", 1'b0);
        ticks(3);
        pop();
        ticks(4);
        check("R3 restart discards ticks", 1'b0);
        ticks(1);
        check("R3 full interval after restart", 1'b1);
    endtask

    task automatic t_trigger();
        fifo_count = 5'd4;
        cyc(1);
        check("R5 clear at trigger", 1'b0);
        ticks(10);
        check("R4 no irq at trigger", 1'b0);
        fifo_count = 5'd3;
        ticks(4);
        check("R4 below trigger counting", 1'b0);
        ticks(1);
        check("R4 below trigger expiry", 1'b1);
    endtask

    task automatic t_empty();
        fifo_count = 5'd0;
        cyc(1);
        check("R6 clear on empty", 1'b0);
        ticks(20);
        check("R6 no irq when empty", 1'b0);
        fifo_count = 5'd2;
        ticks(4);
        check("R6 held at reload", 1'b0);
        ticks(1);
        check("R6 expiry after data arrives", 1'b1);
    endtask

    task automatic t_new_reload();
        pop();
        ticks(2);
        set_reload(9);
        ticks(3);
        check("R9 old value in progress", 1'b1);
        push();
        ticks(8);
        check("R9 new value before expiry", 1'b0);
        ticks(1);
        check("R9 new value expiry", 1'b1);
    endtask

    task automatic t_zero();
        set_reload(0);
        pop();
        ticks(30);
        check("R8 zero reload disables", 1'b0);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_restart();
        t_trigger();
        t_empty();
        t_new_reload();
        t_zero();
        done = 1'b1;
    end

    initial begin
        int n = 0;
        while (!done && n < WATCHDOG) begin
            @(posedge clk);
            n++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: done=0 expected 1");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule